// File: doc/BRIEF.md
# DSI Video-Mode Packet Scheduler

This block produces, frame by frame, the ordered stream of packet descriptors that a DSI video-mode transmitter needs. Each descriptor names a 6-bit data type, a 2-bit virtual channel, a 16-bit word count and a low-power flag. A downstream packet builder consumes the descriptors through a valid/ready handshake and adds headers, ECC, checksums and serialisation.

A start pulse launches one frame. The frame is a vertical sequence of sync lines, back-porch lines, active lines and front-porch lines. Each line is a horizontal sequence of sync packets, blanking fillers and pixel packets. The chosen video mode decides the order of these items. The blanking-interval setting decides whether each filler is a blanking packet, a null packet or a low-power request. Active lines are cut into pixel packets of a programmed maximum length.

The configuration inputs are read live and must stay stable while a frame is in progress.

Top module: `dsi_vsched`

## Requirements
- R1: After reset, and until a start pulse is seen, `desc_valid` stays low.
- R2: A frame visits the regions in this order: vertical sync (`cfg_vsw` lines), vertical back porch (`cfg_vbp` lines), active (`cfg_vact` lines), vertical front porch (`cfg_vfp` lines). A region with a count of zero is skipped. Every line opens with a sync-start packet of word count 0. Its type is 0x01 on the first vertical-sync line and 0x21 on every other line.
- R3: When `cfg_vmode`=0 (pulse), the sync start is followed by a filler of `cfg_hsw` pixels and then a sync-end packet of word count 0. The sync-end type is 0x11 on the last vertical-sync line and 0x31 on every other line. When `cfg_vmode` is 1 (event, and also 3) or 2 (burst), no sync-end packet is sent.
- R4: The fillers after the sync packets depend on the mode.
  - Active line, pulse mode: a filler of hbp, then the pixels, then a filler of hfp.
  - Active line, event mode: a filler of hsw+hbp, then the pixels, then a filler of hfp.
  - Active line, burst mode: the pixels, then one filler of hsw+hbp+hfp.
  - Blanking line: one filler of hbp+hact+hfp in pulse mode, or hsw+hbp+hact+hfp in the other modes.
- R5: An active line of `cfg_hact` pixels is sent as packets of `cfg_ppp` pixels. The last packet carries the remainder. A `cfg_ppp` of 0 sends the whole line as one packet.
- R6: The pixel packet type is {`cfg_fmt`, 4'hE}, that is 0x0E, 0x1E, 0x2E or 0x3E. A word count for n pixels is 2n when fmt=0, ceil(9n/4) when fmt=1, and 3n when fmt is 2 or 3. The same rule applies to filler word counts.
- R7: A filler of n pixels is sent as follows.
  - `cfg_bllp`=0: a descriptor of type 0x00 with `desc_lp`=1 and the word count of n pixels.
  - `cfg_bllp`=1: type 0x19.
  - `cfg_bllp` of 2 or 3: type 0x09.
- R8: When `cfg_eot_en`=1 and `cfg_bllp`=0, every low-power descriptor is immediately preceded by a type 0x08 descriptor of word count 0.
- R9: A filler whose pixel count is zero produces no descriptor at all, and no end-of-transmission packet either.
- R10: While `desc_valid` is high and `desc_ready` is low, the descriptor holds all its fields and stays valid.
- R11: A start pulse during a frame is ignored. A start with all four vertical counts zero produces no descriptors.
- R12: Every descriptor carries `cfg_vc` in `desc_vc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Frame start pulse |
| cfg_vmode | input | 2 | Video mode: 0 pulse, 1/3 event, 2 burst |
| cfg_bllp | input | 2 | Filler kind: 0 low power, 1 blanking, 2/3 null |
| cfg_fmt | input | 2 | Pixel format select |
| cfg_eot_en | input | 1 | End-of-transmission packet before each low-power filler |
| cfg_vc | input | 2 | Virtual channel |
| cfg_hsw | input | HW | Horizontal sync width, pixels |
| cfg_hbp | input | HW | Horizontal back porch, pixels |
| cfg_hact | input | HW | Active pixels per line |
| cfg_hfp | input | HW | Horizontal front porch, pixels |
| cfg_ppp | input | HW | Maximum pixels per pixel packet |
| cfg_vsw | input | VW | Vertical sync lines |
| cfg_vbp | input | VW | Vertical back-porch lines |
| cfg_vact | input | VW | Active lines |
| cfg_vfp | input | VW | Vertical front-porch lines |
| desc_valid | output | 1 | Descriptor valid |
| desc_ready | input | 1 | Descriptor accepted by consumer |
| desc_type | output | 6 | Packet data type |
| desc_vc | output | 2 | Packet virtual channel |
| desc_wc | output | 16 | Packet word count |
| desc_lp | output | 1 | Low-power request instead of a packet |

## Verification
The bench aims at the following corner cases and the way a faulty design would show each one.
- Zero-length intervals: a design that emits an empty filler, or emits an orphan end-of-transmission packet, produces extra descriptors.
- A line width that is not a multiple of the packet size: a design that handles this wrongly either hangs or loses the remainder.
- Zero-count vertical regions: a design that gets these wrong mislabels the 0x01 and 0x11 markers.
- The three mode orderings: each one places the sync width differently, so a wrong ordering shifts word counts between fillers.
- Restart pulses in the middle of a frame: a design that honours them duplicates lines.
- Random backpressure: a design that drops a descriptor on a stall, or changes it during a stall, is caught.

// File: rtl/dsi_vsched_pkg.sv
package dsi_vsched_pkg;

    localparam logic [5:0] DT_VSS   = 6'h01;
    localparam logic [5:0] DT_VSE   = 6'h11;
    localparam logic [5:0] DT_HSS   = 6'h21;
    localparam logic [5:0] DT_HSE   = 6'h31;
    localparam logic [5:0] DT_EOT   = 6'h08;
    localparam logic [5:0] DT_BLANK = 6'h19;
    localparam logic [5:0] DT_NULL  = 6'h09;
    localparam logic [5:0] DT_LPREQ = 6'h00;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SYNC, ST_HSA, ST_SEND, ST_BLK1, ST_PIX, ST_BLK2
    } step_e;

    typedef enum logic [1:0] {
        RG_VSYNC, RG_VBP, RG_VACT, RG_VFP
    } region_e;

    typedef struct packed {
        logic [5:0]  dtype;
        logic [1:0]  vc;
        logic [15:0] wc;
        logic        lp;
    } desc_t;

    function automatic logic [5:0] pix_dtype(input logic [1:0] fmt);
        return {fmt, 4'hE};
    endfunction

    // Bytes needed for a run of pixels in the selected format.
    function automatic logic [15:0] wc_for(input logic [19:0] px, input logic [1:0] fmt);
        logic [21:0] p22;
        logic [21:0] t;
        p22 = {2'b00, px};
        case (fmt)
            2'd0:    t = p22 << 1;
            2'd1:    t = (p22 * 22'd9 + 22'd3) >> 2;
            default: t = p22 * 22'd3;
        endcase
        return t[15:0];
    endfunction

    // Lowest set bit of mask at or above index 'from': {found, index}.
    function automatic logic [2:0] first_set(input logic [3:0] mask, input logic [2:0] from);
        logic [2:0] r;
        r = 3'b000;
        for (int i = 0; i < 4; i++) begin
            if (!r[2] && mask[i] && (3'(i) >= from)) r = {1'b1, 2'(i)};
        end
        return r;
    endfunction

endpackage

// File: rtl/dsi_vsched_vert.sv
module dsi_vsched_vert
    import dsi_vsched_pkg::*;
#(
    parameter int VW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          line_done,
    input  logic [VW-1:0] cnt_vs,
    input  logic [VW-1:0] cnt_vbp,
    input  logic [VW-1:0] cnt_vact,
    input  logic [VW-1:0] cnt_vfp,
    output logic          run,
    output region_e       region,
    output logic          first_line,
    output logic          last_line
);
    localparam int NREG = 4;

    logic [NREG-1:0][VW-1:0] cnt;
    logic [NREG-1:0]         nz;
    logic [VW-1:0]           lcnt;
    logic [1:0]              idx;
    logic [2:0]              pick_start;
    logic [2:0]              pick_next;
    logic                    more_lines;

    assign cnt = {cnt_vfp, cnt_vact, cnt_vbp, cnt_vs};

    for (genvar g = 0; g < NREG; g++) begin : g_nz
        assign nz[g] = (cnt[g] != '0);
    end

    assign pick_start = first_set(nz, 3'd0);
    assign pick_next  = first_set(nz, {1'b0, idx} + 3'd1);
    assign more_lines = ({1'b0, lcnt} + 1'b1) < {1'b0, cnt[idx]};

    always_ff @(posedge clk) begin
        if (rst) begin
            run  <= 1'b0;
            idx  <= 2'd0;
            lcnt <= '0;
        end else if (!run) begin
            if (start && pick_start[2]) begin
                run  <= 1'b1;
                idx  <= pick_start[1:0];
                lcnt <= '0;
            end
        end else if (line_done) begin
            if (more_lines) begin
                lcnt <= lcnt + 1'b1;
            end else if (pick_next[2]) begin
                idx  <= pick_next[1:0];
                lcnt <= '0;
            end else begin
                run <= 1'b0;
            end
        end
    end

    assign region     = region_e'(idx);
    assign first_line = (idx == 2'd0) && (lcnt == '0);
    assign last_line  = (idx == 2'd0) && !more_lines;

endmodule

// File: rtl/dsi_vsched_horz.sv
module dsi_vsched_horz
    import dsi_vsched_pkg::*;
#(
    parameter int HW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          is_act,
    input  logic          vs_first,
    input  logic          vs_last,
    input  logic [1:0]    cfg_vmode,
    input  logic [1:0]    cfg_bllp,
    input  logic [1:0]    cfg_fmt,
    input  logic          cfg_eot_en,
    input  logic [1:0]    cfg_vc,
    input  logic [HW-1:0] cfg_hsw,
    input  logic [HW-1:0] cfg_hbp,
    input  logic [HW-1:0] cfg_hact,
    input  logic [HW-1:0] cfg_hfp,
    input  logic [HW-1:0] cfg_ppp,
    input  logic          ready,
    output logic          valid,
    output desc_t         desc,
    output logic          line_done
);
    localparam int SW = HW + 2;

    step_e         st, nxt;
    logic [HW-1:0] px_done, remaining, chunk;
    logic          eot_sent;
    logic [SW-1:0] w_hsw, w_hbp, w_hact, w_hfp, fill_px;
    logic          pulse, burst, filler, in_eot, fire, advance, last_chunk;

    assign pulse      = (cfg_vmode == 2'd0);
    assign burst      = (cfg_vmode == 2'd2);
    assign w_hsw      = SW'(cfg_hsw);
    assign w_hbp      = SW'(cfg_hbp);
    assign w_hact     = SW'(cfg_hact);
    assign w_hfp      = SW'(cfg_hfp);
    assign remaining  = cfg_hact - px_done;
    assign chunk      = ((cfg_ppp == '0) || (cfg_ppp > remaining)) ? remaining : cfg_ppp;
    assign last_chunk = (chunk == remaining);

    always_comb begin
        case (st)
            ST_HSA:  fill_px = w_hsw;
            ST_BLK1: begin
                if (is_act) fill_px = burst ? '0 : (pulse ? w_hbp : w_hsw + w_hbp);
                else        fill_px = (pulse ? '0 : w_hsw) + w_hbp + w_hact + w_hfp;
            end
            ST_BLK2: fill_px = burst ? (w_hsw + w_hbp + w_hfp) : w_hfp;
            default: fill_px = '0;
        endcase
    end

    assign filler = (st == ST_HSA) || (st == ST_BLK1) || (st == ST_BLK2);
    assign in_eot = filler && (fill_px != '0) && (cfg_bllp == 2'd0) && cfg_eot_en && !eot_sent;

    always_comb begin
        desc  = '{dtype: DT_LPREQ, vc: cfg_vc, wc: 16'd0, lp: 1'b0};
        valid = 1'b0;
        case (st)
            ST_SYNC: begin
                valid      = 1'b1;
                desc.dtype = vs_first ? DT_VSS : DT_HSS;
            end
            ST_SEND: begin
                valid      = 1'b1;
                desc.dtype = vs_last ? DT_VSE : DT_HSE;
            end
            ST_PIX: begin
                valid      = (remaining != '0);
                desc.dtype = pix_dtype(cfg_fmt);
                desc.wc    = wc_for(20'(chunk), cfg_fmt);
            end
            ST_HSA, ST_BLK1, ST_BLK2: begin
                valid = (fill_px != '0);
                if (in_eot) begin
                    desc.dtype = DT_EOT;
                end else begin
                    desc.wc = wc_for(20'(fill_px), cfg_fmt);
                    case (cfg_bllp)
                        2'd0:    desc.lp    = 1'b1;
                        2'd1:    desc.dtype = DT_BLANK;
                        default: desc.dtype = DT_NULL;
                    endcase
                end
            end
            default: ;
        endcase
    end

    assign fire    = valid && ready;
    assign advance = !valid || (fire && !in_eot && !((st == ST_PIX) && !last_chunk));

    always_comb begin
        case (st)
            ST_SYNC: nxt = pulse ? ST_HSA : ST_BLK1;
            ST_HSA:  nxt = ST_SEND;
            ST_SEND: nxt = ST_BLK1;
            ST_BLK1: nxt = is_act ? ST_PIX : ST_IDLE;
            ST_PIX:  nxt = ST_BLK2;
            default: nxt = ST_IDLE;
        endcase
    end

    assign line_done = (st != ST_IDLE) && advance && (nxt == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            px_done  <= '0;
            eot_sent <= 1'b0;
        end else if (st == ST_IDLE) begin
            if (run) begin
                st       <= ST_SYNC;
                px_done  <= '0;
                eot_sent <= 1'b0;
            end
        end else begin
            if (fire && in_eot)        eot_sent <= 1'b1;
            if (fire && st == ST_PIX)  px_done  <= px_done + chunk;
            if (advance) begin
                eot_sent <= 1'b0;
                st       <= nxt;
            end
        end
    end

endmodule

// File: rtl/dsi_vsched.sv
module dsi_vsched
    import dsi_vsched_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [1:0]    cfg_vmode,
    input  logic [1:0]    cfg_bllp,
    input  logic [1:0]    cfg_fmt,
    input  logic          cfg_eot_en,
    input  logic [1:0]    cfg_vc,
    input  logic [HW-1:0] cfg_hsw,
    input  logic [HW-1:0] cfg_hbp,
    input  logic [HW-1:0] cfg_hact,
    input  logic [HW-1:0] cfg_hfp,
    input  logic [HW-1:0] cfg_ppp,
    input  logic [VW-1:0] cfg_vsw,
    input  logic [VW-1:0] cfg_vbp,
    input  logic [VW-1:0] cfg_vact,
    input  logic [VW-1:0] cfg_vfp,
    output logic          desc_valid,
    input  logic          desc_ready,
    output logic [5:0]    desc_type,
    output logic [1:0]    desc_vc,
    output logic [15:0]   desc_wc,
    output logic          desc_lp
);
    logic    frame_run, line_done, first_line, last_line;
    region_e region;
    desc_t   desc;

    dsi_vsched_vert #(.VW(VW)) i_vert (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .line_done  (line_done),
        .cnt_vs     (cfg_vsw),
        .cnt_vbp    (cfg_vbp),
        .cnt_vact   (cfg_vact),
        .cnt_vfp    (cfg_vfp),
        .run        (frame_run),
        .region     (region),
        .first_line (first_line),
        .last_line  (last_line)
    );

    dsi_vsched_horz #(.HW(HW)) i_horz (
        .clk        (clk),
        .rst        (rst),
        .run        (frame_run),
        .is_act     (region == RG_VACT),
        .vs_first   (first_line),
        .vs_last    (last_line),
        .cfg_vmode  (cfg_vmode),
        .cfg_bllp   (cfg_bllp),
        .cfg_fmt    (cfg_fmt),
        .cfg_eot_en (cfg_eot_en),
        .cfg_vc     (cfg_vc),
        .cfg_hsw    (cfg_hsw),
        .cfg_hbp    (cfg_hbp),
        .cfg_hact   (cfg_hact),
        .cfg_hfp    (cfg_hfp),
        .cfg_ppp    (cfg_ppp),
        .ready      (desc_ready),
        .valid      (desc_valid),
        .desc       (desc),
        .line_done  (line_done)
    );

    assign desc_type = desc.dtype;
    assign desc_vc   = desc.vc;
    assign desc_wc   = desc.wc;
    assign desc_lp   = desc.lp;

endmodule

// File: rtl/dsi_vsched_chk.sv
module dsi_vsched_chk (
    input logic        clk,
    input logic        rst,
    input logic        run,
    input logic        desc_valid,
    input logic        desc_ready,
    input logic [5:0]  desc_type,
    input logic [1:0]  desc_vc,
    input logic [15:0] desc_wc,
    input logic        desc_lp,
    input logic [1:0]  cfg_vmode,
    input logic [1:0]  cfg_bllp,
    input logic        cfg_eot_en
);
    logic prev_eot;

    always_ff @(posedge clk) begin
        if (rst)                          prev_eot <= 1'b0;
        else if (desc_valid && desc_ready) prev_eot <= (desc_type == 6'h08);
    end

    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        !run |-> !desc_valid);

    a_r10_hold_stable: assert property (@(posedge clk) disable iff (rst)
        desc_valid && !desc_ready |=> desc_valid && $stable(desc_type) &&
            $stable(desc_wc) && $stable(desc_vc) && $stable(desc_lp));

    a_r7_lp_only_in_lp_mode: assert property (@(posedge clk) disable iff (rst)
        desc_valid && desc_lp |-> cfg_bllp == 2'd0);

    a_r8_eot_before_lp: assert property (@(posedge clk) disable iff (rst)
        desc_valid && desc_lp && cfg_eot_en |-> prev_eot);

    a_r3_no_end_outside_pulse: assert property (@(posedge clk) disable iff (rst)
        desc_valid && (desc_type == 6'h11 || desc_type == 6'h31) |-> cfg_vmode == 2'd0);

endmodule

bind dsi_vsched dsi_vsched_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .run        (frame_run),
    .desc_valid (desc_valid),
    .desc_ready (desc_ready),
    .desc_type  (desc_type),
    .desc_vc    (desc_vc),
    .desc_wc    (desc_wc),
    .desc_lp    (desc_lp),
    .cfg_vmode  (cfg_vmode),
    .cfg_bllp   (cfg_bllp),
    .cfg_eot_en (cfg_eot_en)
);

// File: tb/test_dsi_vsched.sv
`timescale 1ns/1ps
module test_dsi_vsched;
    localparam int HW = 12;
    localparam int VW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [1:0]    cfg_vmode = '0, cfg_bllp = '0, cfg_fmt = '0, cfg_vc = '0;
    logic          cfg_eot_en = 1'b0;
    logic [HW-1:0] cfg_hsw = '0, cfg_hbp = '0, cfg_hact = '0, cfg_hfp = '0, cfg_ppp = '0;
    logic [VW-1:0] cfg_vsw = '0, cfg_vbp = '0, cfg_vact = '0, cfg_vfp = '0;
    logic          desc_valid, desc_lp;
    logic          desc_ready = 1'b0;
    logic [5:0]    desc_type;
    logic [1:0]    desc_vc;
    logic [15:0]   desc_wc;

    dsi_vsched #(.HW(HW), .VW(VW)) i_dsi_vsched (
        .clk(clk), .rst(rst), .start(start),
        .cfg_vmode(cfg_vmode), .cfg_bllp(cfg_bllp), .cfg_fmt(cfg_fmt),
        .cfg_eot_en(cfg_eot_en), .cfg_vc(cfg_vc),
        .cfg_hsw(cfg_hsw), .cfg_hbp(cfg_hbp), .cfg_hact(cfg_hact),
        .cfg_hfp(cfg_hfp), .cfg_ppp(cfg_ppp),
        .cfg_vsw(cfg_vsw), .cfg_vbp(cfg_vbp), .cfg_vact(cfg_vact), .cfg_vfp(cfg_vfp),
        .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_type(desc_type),
        .desc_vc(desc_vc), .desc_wc(desc_wc), .desc_lp(desc_lp)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int rdy_pct = 100;

    int e_type[$], e_wc[$], e_lp[$];
    int c_type[$], c_wc[$], c_lp[$], c_vc[$];

    logic       stall_prev = 1'b0;
    logic [5:0] p_type;
    logic [15:0] p_wc;
    logic       p_lp;
    logic [1:0] p_vc;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int f_bytes(input int px, input int fmt);
        if (fmt == 0) return 2 * px;
        if (fmt == 1) return (9 * px + 3) / 4;
        return 3 * px;
    endfunction

    task automatic push(input int t, input int wc, input int lp);
        e_type.push_back(t); e_wc.push_back(wc); e_lp.push_back(lp);
    endtask

    task automatic add_fill(input int p);
        if (p == 0) return;
        if (cfg_bllp == 2'd0) begin
            if (cfg_eot_en) push('h08, 0, 0);
            push('h00, f_bytes(p, int'(cfg_fmt)), 1);
        end else begin
            push((cfg_bllp == 2'd1) ? 'h19 : 'h09, f_bytes(p, int'(cfg_fmt)), 0);
        end
    endtask

    // Expected frame, built from the requirements.
    task automatic build();
        int cnt[4];
        int hsw, hbp, hact, hfp, ppp;
        bit pulse, burst;
        e_type.delete(); e_wc.delete(); e_lp.delete();
        cnt[0] = int'(cfg_vsw); cnt[1] = int'(cfg_vbp);
        cnt[2] = int'(cfg_vact); cnt[3] = int'(cfg_vfp);
        hsw = int'(cfg_hsw); hbp = int'(cfg_hbp); hact = int'(cfg_hact);
        hfp = int'(cfg_hfp); ppp = int'(cfg_ppp);
        pulse = (cfg_vmode == 2'd0);
        burst = (cfg_vmode == 2'd2);
        for (int r = 0; r < 4; r++) begin
            for (int l = 0; l < cnt[r]; l++) begin
                push((r == 0 && l == 0) ? 'h01 : 'h21, 0, 0);
                if (pulse) begin
                    add_fill(hsw);
                    push((r == 0 && l == cnt[0] - 1) ? 'h11 : 'h31, 0, 0);
                end
                if (r == 2) begin
                    if (!burst) add_fill(pulse ? hbp : hsw + hbp);
                    begin
                        int rem;
                        rem = hact;
                        while (rem > 0) begin
                            int ch;
                            ch = (ppp == 0 || ppp > rem) ? rem : ppp;
                            push(int'(cfg_fmt) * 16 + 14, f_bytes(ch, int'(cfg_fmt)), 0);
                            rem -= ch;
                        end
                    end
                    add_fill(burst ? hsw + hbp + hfp : hfp);
                end else begin
                    add_fill((pulse ? 0 : hsw) + hbp + hact + hfp);
                end
            end
        end
    endtask

    // One cycle: sample at the falling edge, choose ready for the next rising edge.
    task automatic step_cycle();
        @(negedge clk);
        if (stall_prev) begin
            chk(desc_valid && desc_type == p_type && desc_wc == p_wc &&
                desc_lp == p_lp && desc_vc == p_vc, "R10", "stalled descriptor changed",
                int'(desc_wc), int'(p_wc));
        end
        desc_ready = (($urandom % 100) < rdy_pct);
        stall_prev = desc_valid && !desc_ready;
        p_type = desc_type; p_wc = desc_wc; p_lp = desc_lp; p_vc = desc_vc;
        if (desc_valid && desc_ready) begin
            c_type.push_back(int'(desc_type)); c_wc.push_back(int'(desc_wc));
            c_lp.push_back(int'(desc_lp));     c_vc.push_back(int'(desc_vc));
        end
    endtask

    function automatic string tag_for(input int t, input int lp);
        if (lp != 0 || t == 'h19 || t == 'h09) return "R7";
        if (t == 'h01 || t == 'h21) return "R2";
        if (t == 'h11 || t == 'h31) return "R3";
        if (t == 'h08) return "R8";
        return "R6";
    endfunction

    task automatic run_frame(input string tag, input int rdy, input bit restart);
        int guard;
        build();
        c_type.delete(); c_wc.delete(); c_lp.delete(); c_vc.delete();
        rdy_pct = rdy;
        start = 1'b1;
        step_cycle();
        start = 1'b0;
        guard = 0;
        while (c_type.size() < e_type.size() && guard < 20000) begin
            start = (restart && guard == 5);
            step_cycle();
            guard++;
        end
        start = 1'b0;
        repeat (30) step_cycle();
        if (guard >= 20000) chk(1'b0, tag, "frame watchdog", guard, 0);
        chk(c_type.size() == e_type.size(), tag, "descriptor count", c_type.size(), e_type.size());
        for (int i = 0; i < e_type.size() && i < c_type.size(); i++) begin
            string t;
            t = tag_for(e_type[i], e_lp[i]);
            chk(c_type[i] == e_type[i], t, $sformatf("type at %0d", i), c_type[i], e_type[i]);
            chk(c_wc[i] == e_wc[i], t, $sformatf("word count at %0d", i), c_wc[i], e_wc[i]);
            chk(c_lp[i] == e_lp[i], t, $sformatf("lp flag at %0d", i), c_lp[i], e_lp[i]);
            chk(c_vc[i] == int'(cfg_vc), "R12", $sformatf("vc at %0d", i), c_vc[i], int'(cfg_vc));
        end
    endtask

    task automatic set_h(input int vm, input int bl, input int fm, input int eot,
                         input int hsw, input int hbp, input int hact, input int hfp, input int ppp);
        cfg_vmode = 2'(vm); cfg_bllp = 2'(bl); cfg_fmt = 2'(fm); cfg_eot_en = 1'(eot);
        cfg_hsw = HW'(hsw); cfg_hbp = HW'(hbp); cfg_hact = HW'(hact);
        cfg_hfp = HW'(hfp); cfg_ppp = HW'(ppp);
    endtask

    task automatic set_v(input int vs, input int vb, input int va, input int vf);
        cfg_vsw = VW'(vs); cfg_vbp = VW'(vb); cfg_vact = VW'(va); cfg_vfp = VW'(vf);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!desc_valid, "R1", "valid during reset", int'(desc_valid), 0);
        rst = 1'b0;
        set_h(0, 1, 3, 0, 2, 3, 8, 1, 4);
        set_v(1, 1, 2, 1);
        for (int i = 0; i < 8; i++) begin
            step_cycle();
            chk(!desc_valid, "R1", "valid before start", int'(desc_valid), 0);
        end

        cfg_vc = 2'd1;
        run_frame("R4", 100, 1'b0);            // pulse ordering
        set_h(1, 1, 3, 0, 2, 3, 8, 1, 4);
        run_frame("R4", 100, 1'b0);            // event ordering
        set_h(2, 2, 0, 0, 2, 3, 8, 1, 4);
        run_frame("R4", 70, 1'b0);             // burst ordering
        set_h(1, 2, 1, 0, 1, 2, 10, 2, 4);
        run_frame("R5", 100, 1'b0);            // remainder packet
        set_h(0, 1, 2, 0, 1, 1, 7, 1, 0);
        run_frame("R5", 100, 1'b0);            // whole line in one packet
        set_h(0, 0, 0, 1, 0, 0, 6, 0, 3);
        set_v(1, 0, 2, 0);
        run_frame("R9", 100, 1'b0);            // zero-length intervals
        set_h(1, 0, 1, 1, 2, 1, 5, 3, 2);
        set_v(2, 1, 2, 2);
        cfg_vc = 2'd3;
        run_frame("R8", 40, 1'b0);             // eot before low power, with stalls
        set_v(0, 0, 0, 0);
        run_frame("R11", 100, 1'b0);           // empty frame
        set_h(0, 2, 3, 0, 1, 1, 6, 1, 3);
        set_v(2, 1, 2, 1);
        run_frame("R11", 80, 1'b1);            // restart pulse mid-frame

        for (int k = 0; k < 24; k++) begin
            set_h($urandom % 4, $urandom % 4, $urandom % 4, $urandom % 2,
                  $urandom % 4, $urandom % 4, 1 + $urandom % 16, $urandom % 4, $urandom % 7);
            set_v($urandom % 3, $urandom % 3, 1 + $urandom % 3, $urandom % 3);
            cfg_vc = 2'($urandom % 4);
            run_frame("R6", 50 + $urandom % 51, 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule